// File: doc/BRIEF.md
# Byte-Wide Handshaked Register Bus Slave

This block is the fabric-side end of an 8-bit parallel link to a host microcontroller. The host and the fabric share no clock. Every control line from the host goes through a two-flop synchroniser. Each byte moves under a four-phase handshake: the host raises its strobe, the slave answers, the host drops its strobe, and the slave drops its answer. One transaction is a framed packet of six request bytes sent to the slave: a command byte, a register-number byte, and a 32-bit word sent low byte first. The slave then makes one access on a simple register-file interface and returns the reply, also low byte first. The reply is a 32-bit data word, optionally followed by a 32-bit status word.

The host picks the bus direction with a read/write line. The slave drives the byte lane only in the reply phase, and only while that line says the host is reading. At all other times it holds its output enable low. Register number 0 is answered inside the block with an identification word built from parameters, and it never reaches the register file. A host-side reset line aborts whatever transaction is in progress.

Top module: `hbs_top`

## Requirements
- R1: After fabric reset (rstN low) slvAck, slvHs2 and busDataOe are all 0, and no register strobe is active.
- R2: Request bytes are taken in this order: command, register number, then data bytes 0 to 3, lowest byte first. regAddr shows the register number and regWrData shows the assembled word while the access is made.
- R3: A command byte of 1 (write) to a nonzero register pulses regWrEn for exactly one cycle and never pulses regRdEn. The reply data word is the written word echoed back.
- R4: A command byte of 0 (read) to a nonzero register pulses regRdEn for exactly one cycle and never pulses regWrEn. The reply data word is regRdData as sampled in that cycle.
- R5: Register number 0 pulses neither strobe. A read of it returns the identification word: major version in bits 31:28, minor version in bits 27:24, PWM channel count in 23:16, encoder channel count in 15:8 and servo channel count in 7:0. A write to it is ignored, and the reply is still the identification word.
- R6: A command byte other than 0 or 1 pulses no strobe and returns a data word of 0.
- R7: With REPLY_WORDS = 2 the reply is eight bytes: the data word, then the regStatus word sampled at the access, each lowest byte first. Each byte is on busDataOut when slvHs2 rises and stays stable until slvHs2 falls.
- R8: busDataOe is 1 only during the reply phase while the synchronised hostRw is 0. It is 0 throughout the request phase, after the reply and while idle.
- R9: slvHs2 rises only after hostHs1 is seen high through the synchroniser. It falls only after hostHs1 is seen low, or on an abort.
- R10: slvAck rises in the same cycle in which the last reply byte's slvHs2 falls. It stays high until the host drops hostStart, then returns to 0. slvHs2 is 0 while slvAck is 1.
- R11: Raising hostReset at any point of a transaction returns slvAck, slvHs2 and busDataOe to 0 and pulses no strobe. The next transaction then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Fabric reset, active low, synchronous |
| hostStart | input | 1 | Host frames a transaction (asynchronous) |
| hostRw | input | 1 | 1 = host drives the byte lane, 0 = slave drives it (asynchronous) |
| hostHs1 | input | 1 | Host byte strobe (asynchronous) |
| hostReset | input | 1 | Host abort request, active high (asynchronous) |
| busDataIn | input | 8 | Byte lane as seen from the pads |
| busDataOut | output | 8 | Reply byte toward the pads |
| busDataOe | output | 1 | Output enable of the byte-lane pad drivers |
| slvAck | output | 1 | Packet complete |
| slvHs2 | output | 1 | Slave byte answer |
| regAddr | output | 8 | Register number of the access |
| regWrData | output | 32 | Word to be written |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 32 | Read value of the addressed register |
| regStatus | input | 32 | Status word returned after the data word |

## Verification
The hardest condition to reach from the ports is an abort that lands while the slave is driving the lane, with reply bytes still outstanding. There the output enable, the handshake answer and the loaded reply register must all let go at the same time. The bench gets there by completing a full request, switching the direction line, taking two reply bytes, and only then raising the host reset. It then runs a clean read to show that no remaining reply byte leaks into the next packet. The other abort case is a reset after a partial request, followed by a write whose strobe count and stored value are both checked.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_HI,
    ST_REQ_LO,
    ST_ACCESS,
    ST_RPL_HI,
    ST_RPL_LO,
    ST_DONE
  } hbs_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take busDataIn into request register
    logic load;      // load reply register
    logic shift;     // advance reply register by one byte
  } hbs_strobe_t;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/hbs_datapath.sv
module hbs_datapath import hbs_pkg::*; #(
  parameter int                  DATA_W      = 32,
  parameter int                  ADDR_W      = 8,
  parameter int                  REPLY_WORDS = 2,
  parameter logic [DATA_W-1:0]   ID_WORD     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbs_strobe_t       strobe,
  input  logic [BYTE_W-1:0] busDataIn,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] regStatus,
  output logic [BYTE_W-1:0] busDataOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              isRead,
  output logic              isWrite,
  output logic              isId
);

  localparam int REQ_W = 2 * BYTE_W + DATA_W;
  localparam int RPL_W = REPLY_WORDS * DATA_W;

  logic [REQ_W-1:0]  reqReg;
  logic [RPL_W-1:0]  rplReg;
  logic [RPL_W-1:0]  rplLoad;
  logic [DATA_W-1:0] dataWord;
  logic [BYTE_W-1:0] cmdByte;

  // request bytes arrive lowest first; shift in at the top
  always_ff @(posedge clk) begin
    if (!rstN)               reqReg <= '0;
    else if (strobe.capture) reqReg <= {busDataIn, reqReg[REQ_W-1:BYTE_W]};
  end

  assign cmdByte   = reqReg[BYTE_W-1:0];
  assign regAddr   = reqReg[BYTE_W +: ADDR_W];
  assign regWrData = reqReg[2*BYTE_W +: DATA_W];
  assign isId      = (regAddr == '0);
  assign isRead    = (cmdByte == CMD_READ);
  assign isWrite   = (cmdByte == CMD_WRITE);

  always_comb begin
    if (isId)         dataWord = ID_WORD;
    else if (isWrite) dataWord = regWrData;
    else if (isRead)  dataWord = regRdData;
    else              dataWord = '0;
  end

  generate
    if (REPLY_WORDS == 2) begin : g_withStatus
      assign rplLoad = {regStatus, dataWord};
    end else begin : g_dataOnly
      assign rplLoad = dataWord;
      logic unusedStatus;
      assign unusedStatus = ^regStatus;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             rplReg <= '0;
    else if (strobe.load)  rplReg <= rplLoad;
    else if (strobe.shift) rplReg <= {{BYTE_W{1'b0}}, rplReg[RPL_W-1:BYTE_W]};
  end

  assign busDataOut = rplReg[BYTE_W-1:0];

endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl import hbs_pkg::*; #(
  parameter int REQ_BYTES = 6,
  parameter int RPL_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startS,
  input  logic        hs1S,
  input  logic        rwS,
  input  logic        abortS,
  input  logic        isRead,
  input  logic        isWrite,
  input  logic        isId,
  output hbs_strobe_t strobe,
  output logic        hs2,
  output logic        ack,
  output logic        oe,
  output logic        wrEn,
  output logic        rdEn
);

  localparam int MAX_BYTES = (REQ_BYTES > RPL_BYTES) ? REQ_BYTES : RPL_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_BYTES - 1);
  localparam logic [CNT_W-1:0] RPL_LAST = CNT_W'(RPL_BYTES - 1);

  hbs_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe.capture = !abortS && (state == ST_REQ_HI) && hs1S;
    strobe.load    = !abortS && (state == ST_ACCESS);
    strobe.shift   = !abortS && (state == ST_RPL_LO) && !hs1S;
    wrEn           = strobe.load && isWrite && !isId;
    rdEn           = strobe.load && isRead && !isId;
    oe             = ((state == ST_RPL_HI) || (state == ST_RPL_LO)) && !rwS;
  end

  always_ff @(posedge clk) begin
    if (!rstN || abortS) begin
      state <= ST_IDLE;
      cnt   <= '0;
      hs2   <= 1'b0;
      ack   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startS) state <= ST_REQ_HI;
        end
        ST_REQ_HI: if (hs1S) begin
          hs2   <= 1'b1;
          state <= ST_REQ_LO;
        end
        ST_REQ_LO: if (!hs1S) begin
          hs2 <= 1'b0;
          if (cnt == REQ_LAST) begin
            cnt   <= '0;
            state <= ST_ACCESS;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= ST_REQ_HI;
          end
        end
        ST_ACCESS: state <= ST_RPL_HI;
        ST_RPL_HI: if (hs1S) begin
          hs2   <= 1'b1;
          state <= ST_RPL_LO;
        end
        ST_RPL_LO: if (!hs1S) begin
          hs2 <= 1'b0;
          if (cnt == RPL_LAST) begin
            ack   <= 1'b1;
            state <= ST_DONE;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= ST_RPL_HI;
          end
        end
        ST_DONE: if (!startS) begin
          ack   <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hbs_top.sv
module hbs_top import hbs_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int REPLY_WORDS = 2,
  parameter int SYNC_STAGES = 2,
  parameter int VER_MAJOR   = 1,
  parameter int VER_MINOR   = 2,
  parameter int NUM_PWM     = 4,
  parameter int NUM_ENC     = 4,
  parameter int NUM_SERVO   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStart,
  input  logic              hostRw,
  input  logic              hostHs1,
  input  logic              hostReset,
  input  logic [7:0]        busDataIn,
  output logic [7:0]        busDataOut,
  output logic              busDataOe,
  output logic              slvAck,
  output logic              slvHs2,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] regStatus
);

  localparam int WORD_BYTES = DATA_W / BYTE_W;
  localparam int REQ_BYTES  = 2 + WORD_BYTES;
  localparam int RPL_BYTES  = REPLY_WORDS * WORD_BYTES;
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({4'(VER_MAJOR), 4'(VER_MINOR),
                                                   8'(NUM_PWM), 8'(NUM_ENC), 8'(NUM_SERVO)});

  logic [3:0]  syncVec;
  logic        startSync, rwSync, hs1Sync, hostRstSync;
  hbs_strobe_t strobe;
  logic        isRead, isWrite, isId;

  hbs_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({hostReset, hostHs1, hostRw, hostStart}),
    .syncOut (syncVec)
  );

  assign {hostRstSync, hs1Sync, rwSync, startSync} = syncVec;

  hbs_ctrl #(.REQ_BYTES(REQ_BYTES), .RPL_BYTES(RPL_BYTES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startS  (startSync),
    .hs1S    (hs1Sync),
    .rwS     (rwSync),
    .abortS  (hostRstSync),
    .isRead  (isRead),
    .isWrite (isWrite),
    .isId    (isId),
    .strobe  (strobe),
    .hs2     (slvHs2),
    .ack     (slvAck),
    .oe      (busDataOe),
    .wrEn    (regWrEn),
    .rdEn    (regRdEn)
  );

  hbs_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REPLY_WORDS(REPLY_WORDS), .ID_WORD(ID_WORD)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busDataIn  (busDataIn),
    .regRdData  (regRdData),
    .regStatus  (regStatus),
    .busDataOut (busDataOut),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .isRead     (isRead),
    .isWrite    (isWrite),
    .isId       (isId)
  );

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hs1Sync,
  input logic              hostRstSync,
  input logic              slvHs2,
  input logic              slvAck,
  input logic              busDataOe,
  input logic [7:0]        busDataOut,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr
);

  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R3
  AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn)); // R3
  AST_ID_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> (regAddr != '0)); // R5
  AST_HS2_RISE_AFTER_HS1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slvHs2) |-> $past(hs1Sync)); // R9
  AST_HS2_FALL_AFTER_HS1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slvHs2) |-> (!$past(hs1Sync) || $past(hostRstSync))); // R9
  AST_ACK_QUIET_LANE: assert property (@(posedge clk) disable iff (!rstN)
    slvAck |-> (!busDataOe && !slvHs2)); // R10
  AST_REPLY_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (slvHs2 && busDataOe && $past(slvHs2) && $past(busDataOe)) |-> $stable(busDataOut)); // R7
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    hostRstSync |=> (!slvHs2 && !slvAck)); // R11

endmodule

bind hbs_top hbs_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .hs1Sync     (hs1Sync),
  .hostRstSync (hostRstSync),
  .slvHs2      (slvHs2),
  .slvAck      (slvAck),
  .busDataOe   (busDataOe),
  .busDataOut  (busDataOut),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr)
);

// File: tb/hbs_top_tb_top.sv
`timescale 1ns/1ps
module hbs_top_tb_top;

  localparam int VMAJ = 1, VMIN = 2, NPWM = 4, NENC = 4, NSRV = 8;
  localparam logic [31:0] ID_EXP = (32'(VMAJ) << 28) | (32'(VMIN) << 24) |
                                   (32'(NPWM) << 16) | (32'(NENC) << 8) | 32'(NSRV);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostStart = 1'b0, hostRw = 1'b0, hostHs1 = 1'b0, hostReset = 1'b0;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  busDataOut;
  logic        busDataOe, slvAck, slvHs2, regWrEn, regRdEn;
  logic [7:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic [31:0] regStatus = '0;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int wrCount = 0;
  int rdCount = 0;
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  hbs_top #(.VER_MAJOR(VMAJ), .VER_MINOR(VMIN), .NUM_PWM(NPWM),
            .NUM_ENC(NENC), .NUM_SERVO(NSRV)) dut_i (
    .clk(clk), .rstN(rstN), .hostStart(hostStart), .hostRw(hostRw),
    .hostHs1(hostHs1), .hostReset(hostReset), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .slvAck(slvAck),
    .slvHs2(slvHs2), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
    .regStatus(regStatus)
  );

  // register file model
  assign regRdData = mem[regAddr];
  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdEn) rdCount <= rdCount + 1;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitHs2(input logic lvl);
    while (slvHs2 !== lvl) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    busDataIn = b;
    hostHs1 = 1'b1;
    waitHs2(1'b1);
    check("R8 lane released in request", 32'(busDataOe), 32'd0);
    hostHs1 = 1'b0;
    waitHs2(1'b0);
  endtask

  task automatic recvByte(output logic [7:0] b);
    hostHs1 = 1'b1;
    waitHs2(1'b1);
    check("R8 lane driven in reply", 32'(busDataOe), 32'd1);
    b = busDataOut;
    hostHs1 = 1'b0;
    waitHs2(1'b0);
  endtask

  task automatic sendRequest(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data);
    hostRw = 1'b1;
    hostStart = 1'b1;
    sendByte(cmd);
    sendByte(addr);
    for (int i = 0; i < 4; i++) sendByte(data[8*i +: 8]);
  endtask

  task automatic transact(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                          output logic [31:0] rdat, output logic [31:0] rsts);
    logic [7:0] b;
    sendRequest(cmd, addr, data);
    hostRw = 1'b0;
    for (int i = 0; i < 4; i++) begin recvByte(b); rdat[8*i +: 8] = b; end
    for (int i = 0; i < 4; i++) begin recvByte(b); rsts[8*i +: 8] = b; end
    check("R10 ack after last byte", 32'(slvAck), 32'd1);
    check("R10 ack holds while start high", 32'(slvAck & !busDataOe), 32'd1);
    hostStart = 1'b0;
    hostRw = 1'b1;
    idle(4);
    check("R10 ack drops after start low", 32'(slvAck), 32'd0);
  endtask

  // full transaction with expected values: kind 0 read, 1 write, 2 id, 3 bad cmd
  task automatic runOne(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] data,
                        input logic [31:0] sts);
    logic [31:0] rd, rs, expD, memBefore;
    int w0, r0, expW, expR;
    w0 = wrCount; r0 = rdCount;
    memBefore = mem[addr];
    regStatus = sts;
    transact(cmd, addr, data, rd, rs);
    expW = 0; expR = 0;
    if (addr == 8'd0)       expD = ID_EXP;
    else if (cmd == 8'd1) begin expD = data; expW = 1; end
    else if (cmd == 8'd0) begin expD = memBefore; expR = 1; end
    else                    expD = 32'd0;
    if (addr == 8'd0)       check("R5 identification word", rd, expD);
    else if (cmd == 8'd1)   check("R3 write echo", rd, expD);
    else if (cmd == 8'd0)   check("R4 read data", rd, expD);
    else                    check("R6 unknown command data", rd, expD);
    check("R7 status word", rs, sts);
    check("R3 write strobe count", 32'(wrCount - w0), 32'(expW));
    check("R4 read strobe count", 32'(rdCount - r0), 32'(expR));
    if (expW == 1) check("R2 stored word at register", mem[addr], data);
    else           check("R6 register untouched", mem[addr], memBefore);
  endtask

  initial begin
    logic [7:0] b;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    idle(3);
    check("R1 ack in reset", 32'(slvAck), 32'd0);
    check("R1 hs2 in reset", 32'(slvHs2), 32'd0);
    check("R1 oe in reset", 32'(busDataOe), 32'd0);
    rstN = 1'b1;
    idle(3);
    check("R1 idle outputs", {29'd0, slvAck, slvHs2, busDataOe}, 32'd0);
    check("R1 no strobe", 32'(wrCount + rdCount), 32'd0);

    // R2 R3: write sweep over registers 1..15
    for (int a = 1; a < 16; a++) begin
      logic [31:0] d;
      d = {8'(a), ~8'(a), 8'hA5 ^ 8'(a), 8'(a * 3)};
      runOne(8'd1, 8'(a), d, 32'h5A00_0000 | 32'(a));
    end
    // R4: read them back
    for (int a = 1; a < 16; a++)
      runOne(8'd0, 8'(a), 32'hFFFF_FFFF, 32'hC3C3_0000 + 32'(a << 4));
    // R5: identification register, read and write
    runOne(8'd0, 8'd0, 32'h0, 32'h1111_2222);
    runOne(8'd1, 8'd0, 32'hBAD0_BAD0, 32'h3333_4444);
    // R6: other command codes
    for (int c = 2; c < 6; c++) runOne(8'(c), 8'd7, 32'h0F0F_0F0F, 32'(c));
    runOne(8'hFF, 8'd200, 32'h1234_5678, 32'hFEED_BEEF);
    // high address, read of untouched register
    runOne(8'd0, 8'd255, 32'h0, 32'h0);

    // R11: abort during request
    hostRw = 1'b1; hostStart = 1'b1;
    sendByte(8'd1); sendByte(8'd9); sendByte(8'h77);
    hostReset = 1'b1;
    idle(4);
    check("R11 quiet after request abort", {29'd0, slvAck, slvHs2, busDataOe}, 32'd0);
    hostReset = 1'b0; hostStart = 1'b0;
    idle(4);
    check("R11 no strobe on abort", 32'(mem[9]), 32'({8'd9, ~8'd9, 8'hA5 ^ 8'd9, 8'd27}));
    runOne(8'd1, 8'd9, 32'h9999_0001, 32'h0000_0009);

    // R11: abort while slave drives reply bytes
    regStatus = 32'hABCD_EF01;
    sendRequest(8'd0, 8'd3, 32'h0);
    hostRw = 1'b0;
    recvByte(b); recvByte(b);
    hostHs1 = 1'b1;
    idle(1);
    hostReset = 1'b1;
    idle(4);
    check("R11 quiet after reply abort", {29'd0, slvAck, slvHs2, busDataOe}, 32'd0);
    hostHs1 = 1'b0; hostReset = 1'b0; hostStart = 1'b0; hostRw = 1'b1;
    idle(4);
    runOne(8'd0, 8'd9, 32'h0, 32'h7777_8888);

    summary();
    $finish;
  end

endmodule